// File: doc/BRIEF.md
# MESI Cache Line State Controller

This block holds the coherence state of every line in a small write-back data cache. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. Four kinds of event arrive on strobes, each with a line index. A line-fill completion carries a page write-through bit and a write-back/write-through input. A processor write carries a hit flag. A snoop carries a hit flag and an invalidate qualifier. A flush request arrives on an active-low input. For each event the block updates the addressed line. One clock later it reports whether the cache must issue a write-through on the external bus, whether a line must be copied back, and whether the snoop found dirty data. Tag lookup, data storage, the bus engine and replacement are done elsewhere.

The block accepts one event per clock. A flush starts a sweep state machine with two states, FL_IDLE and FL_SWEEP. The sweep visits the lines one per clock in index order, requests a copy-back for each dirty line and invalidates every line. The per-line transitions are named as follows:
- fill-to-exclusive: Invalid/any to Exclusive.
- fill-to-shared: any to Shared.
- write-dirty: Exclusive to Modified.
- write-through: Shared to Shared, with a bus write.
- write-silent: Modified to Modified.
- write-miss: no change.
- snoop-share: Modified or Exclusive to Shared.
- snoop-kill: any to Invalid.
- sweep-kill: any to Invalid.

A query port shows the state of any line.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `qry_state`. The encoding is 00 Invalid, 01 Shared, 10 Exclusive, 11 Modified. `qry_state` shows the current state of line `qry_idx` without delay.
- R2: A fill completion with `fill_pwt`=0 puts the line in Exclusive (10) if `fill_wbwt`=1, and in Shared (01) if `fill_wbwt`=0.
- R3: A fill completion with `fill_pwt`=1 puts the line in Shared (01), whatever the value of `fill_wbwt`.
- R4: A write hit to an Exclusive line moves it to Modified and raises no action output.
- R5: A write hit to a Shared line raises `wt_req`, and the line stays Shared.
- R6: A write hit to a Modified line raises no action output and leaves the line Modified.
- R7: A write with `wr_hit`=0, or a write to an Invalid line, raises `wr_miss` and changes no state.
- R8: A snoop hit with `snoop_inv`=1 moves the line to Invalid. If the line was Modified, `snoop_hitm` and `cb_req` are both raised.
- R9: A snoop hit with `snoop_inv`=0 moves a Modified or Exclusive line to Shared and leaves a Shared or Invalid line as it is. A Modified line raises `snoop_hitm` and `cb_req`. A snoop with `snoop_hit`=0 has no effect.
- R10: `flush_n` low while no sweep runs starts a sweep. `flush_busy` is high from the next clock for N_LINES clocks. On each of those clocks one line is invalidated, in ascending index order. `cb_req` is raised with `act_idx` for each line that was Modified.
- R11: Only one event is accepted per clock. The priority is: sweep in progress, then flush request, then snoop, then fill, then write. A lower-priority strobe in the same clock is dropped.
- R12: `wt_req`, `cb_req`, `snoop_hitm` and `wr_miss` are registered. They appear one clock after the event, with the line index on `act_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_n | input | 1 | Active-low flush request |
| snoop_valid | input | 1 | Snoop event strobe |
| snoop_hit | input | 1 | Snoop address matched a cached line |
| snoop_inv | input | 1 | Snoop requires invalidation |
| snoop_idx | input | IDX_W | Line index of the snoop |
| fill_done | input | 1 | Line fill completed |
| fill_idx | input | IDX_W | Line index of the fill |
| fill_pwt | input | 1 | Page write-through bit |
| fill_wbwt | input | 1 | External write-back (1) / write-through (0) input |
| wr_valid | input | 1 | Processor write strobe |
| wr_hit | input | 1 | Processor write hit the cache |
| wr_idx | input | IDX_W | Line index of the write |
| qry_idx | input | IDX_W | Line to show on qry_state |
| qry_state | output | 2 | State of line qry_idx |
| flush_busy | output | 1 | Flush sweep in progress |
| wt_req | output | 1 | Write-through to the external bus required |
| cb_req | output | 1 | Copy-back of the line required |
| snoop_hitm | output | 1 | Snoop hit a Modified line |
| wr_miss | output | 1 | Processor write missed |
| act_idx | output | IDX_W | Line index for the action outputs |

## Verification
The bench checks the page write-through override on a fill. A design that honoured the external pin instead would leave the line Exclusive, and a later write would then go dirty silently rather than writing through. The bench snoops a Modified line with and without invalidate. A design that dropped the copy-back would lose dirty data, and one that got the invalidate qualifier wrong would leave a stale Shared copy or invalidate needlessly. The bench sends coinciding strobes, and sends strobes during a flush sweep, to expose an inverted priority or a sweep that can be interrupted. It also counts the copy-backs the sweep produces, to catch a sweep that skips a line or stops one line early.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_EXC = 2'b10,
        LN_MOD = 2'b11
    } line_st_t;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_SWEEP = 3'd1,
        EV_SNOOP = 3'd2,
        EV_FILL  = 3'd3,
        EV_WRITE = 3'd4
    } ev_kind_t;

    typedef struct packed {
        logic wt;
        logic cb;
        logic hitm;
        logic miss;
    } act_t;

endpackage

// File: rtl/mesi_event_arb.sv
module mesi_event_arb
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             sweep_busy,
    input  logic [IDX_W-1:0] sweep_idx,
    input  logic             flush_n,
    input  logic             snoop_valid,
    input  logic             snoop_hit,
    input  logic             snoop_inv,
    input  logic [IDX_W-1:0] snoop_idx,
    input  logic             fill_done,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_pwt,
    input  logic             fill_wbwt,
    input  logic             wr_valid,
    input  logic             wr_hit,
    input  logic [IDX_W-1:0] wr_idx,
    output ev_kind_t         ev_kind,
    output logic [IDX_W-1:0] ev_idx,
    output logic             ev_hit,
    output logic             ev_inv,
    output logic             ev_pwt,
    output logic             ev_wbwt,
    output logic             sweep_start
);

    always_comb begin
        ev_kind     = EV_NONE;
        ev_idx      = '0;
        ev_hit      = 1'b0;
        ev_inv      = 1'b0;
        ev_pwt      = 1'b0;
        ev_wbwt     = 1'b0;
        sweep_start = 1'b0;
        if (sweep_busy) begin
            ev_kind = EV_SWEEP;
            ev_idx  = sweep_idx;
        end else if (!flush_n) begin
            sweep_start = 1'b1;
        end else if (snoop_valid) begin
            ev_kind = EV_SNOOP;
            ev_idx  = snoop_idx;
            ev_hit  = snoop_hit;
            ev_inv  = snoop_inv;
        end else if (fill_done) begin
            ev_kind = EV_FILL;
            ev_idx  = fill_idx;
            ev_pwt  = fill_pwt;
            ev_wbwt = fill_wbwt;
        end else if (wr_valid) begin
            ev_kind = EV_WRITE;
            ev_idx  = wr_idx;
            ev_hit  = wr_hit;
        end
    end

endmodule

// File: rtl/mesi_line_xfer.sv
module mesi_line_xfer
    import mesi_pkg::*;
(
    input  ev_kind_t kind,
    input  line_st_t cur,
    input  logic     hit,
    input  logic     inv,
    input  logic     pwt,
    input  logic     wbwt,
    output line_st_t nxt,
    output act_t     act
);

    always_comb begin
        nxt = cur;
        act = '0;
        unique case (kind)
            EV_NONE: begin
            end
            EV_SWEEP: begin
                act.cb = (cur == LN_MOD);
                nxt    = LN_INV;
            end
            EV_SNOOP: begin
                if (hit) begin
                    act.hitm = (cur == LN_MOD);
                    act.cb   = (cur == LN_MOD);
                    if (inv) begin
                        nxt = LN_INV;
                    end else begin
                        unique case (cur)
                            LN_MOD, LN_EXC: nxt = LN_SHR;
                            default:        nxt = cur;
                        endcase
                    end
                end
            end
            EV_FILL: begin
                nxt = (pwt || !wbwt) ? LN_SHR : LN_EXC;
            end
            EV_WRITE: begin
                if (!hit) begin
                    act.miss = 1'b1;
                end else begin
                    unique case (cur)
                        LN_INV: act.miss = 1'b1;
                        LN_SHR: act.wt   = 1'b1;
                        LN_EXC: nxt      = LN_MOD;
                        LN_MOD: nxt      = LN_MOD;
                    endcase
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mesi_flush_fsm.sv
module mesi_flush_fsm #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LINES - 1);

    typedef enum logic {FL_IDLE = 1'b0, FL_SWEEP = 1'b1} fl_st_t;

    fl_st_t           fs_q, fs_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= FL_IDLE;
            ptr_q <= '0;
        end else begin
            fs_q  <= fs_d;
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        fs_d  = fs_q;
        ptr_d = ptr_q;
        unique case (fs_q)
            FL_IDLE: begin
                if (start) begin
                    fs_d  = FL_SWEEP;
                    ptr_d = '0;
                end
            end
            FL_SWEEP: begin
                if (ptr_q == LAST) begin
                    fs_d  = FL_IDLE;
                    ptr_d = '0;
                end else begin
                    ptr_d = ptr_q + 1'b1;
                end
            end
        endcase
    end

    assign busy = (fs_q == FL_SWEEP);
    assign ptr  = ptr_q;

    p_sweep_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_q == FL_SWEEP && ptr_q == LAST) |=> (fs_q == FL_IDLE));

    p_sweep_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_q == FL_SWEEP && ptr_q != LAST) |=> (fs_q == FL_SWEEP && ptr_q == $past(ptr_q) + 1'b1));

    p_idle_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_q == FL_IDLE) |-> (ptr_q == '0));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_n,
    input  logic             snoop_valid,
    input  logic             snoop_hit,
    input  logic             snoop_inv,
    input  logic [IDX_W-1:0] snoop_idx,
    input  logic             fill_done,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_pwt,
    input  logic             fill_wbwt,
    input  logic             wr_valid,
    input  logic             wr_hit,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] qry_idx,
    output logic [1:0]       qry_state,
    output logic             flush_busy,
    output logic             wt_req,
    output logic             cb_req,
    output logic             snoop_hitm,
    output logic             wr_miss,
    output logic [IDX_W-1:0] act_idx
);

    line_st_t         st_q [N_LINES];
    ev_kind_t         ev_kind;
    logic [IDX_W-1:0] ev_idx;
    logic             ev_hit, ev_inv, ev_pwt, ev_wbwt;
    logic             sweep_start, sweep_busy;
    logic [IDX_W-1:0] sweep_idx;
    line_st_t         cur_st, nxt_st;
    act_t             act;
    logic [N_LINES-1:0] line_sel;

    mesi_flush_fsm #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sweep_start),
        .busy  (sweep_busy),
        .ptr   (sweep_idx)
    );

    mesi_event_arb #(.IDX_W(IDX_W)) u_arb (
        .sweep_busy  (sweep_busy),
        .sweep_idx   (sweep_idx),
        .flush_n     (flush_n),
        .snoop_valid (snoop_valid),
        .snoop_hit   (snoop_hit),
        .snoop_inv   (snoop_inv),
        .snoop_idx   (snoop_idx),
        .fill_done   (fill_done),
        .fill_idx    (fill_idx),
        .fill_pwt    (fill_pwt),
        .fill_wbwt   (fill_wbwt),
        .wr_valid    (wr_valid),
        .wr_hit      (wr_hit),
        .wr_idx      (wr_idx),
        .ev_kind     (ev_kind),
        .ev_idx      (ev_idx),
        .ev_hit      (ev_hit),
        .ev_inv      (ev_inv),
        .ev_pwt      (ev_pwt),
        .ev_wbwt     (ev_wbwt),
        .sweep_start (sweep_start)
    );

    assign cur_st = st_q[ev_idx];

    mesi_line_xfer u_xfer (
        .kind (ev_kind),
        .cur  (cur_st),
        .hit  (ev_hit),
        .inv  (ev_inv),
        .pwt  (ev_pwt),
        .wbwt (ev_wbwt),
        .nxt  (nxt_st),
        .act  (act)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_sel
        assign line_sel[g] = (ev_kind != EV_NONE) && (ev_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_LINES; i++) begin
            if (!rst_n) begin
                st_q[i] <= LN_INV;
            end else if (line_sel[i]) begin
                st_q[i] <= nxt_st;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wt_req     <= 1'b0;
            cb_req     <= 1'b0;
            snoop_hitm <= 1'b0;
            wr_miss    <= 1'b0;
            act_idx    <= '0;
        end else begin
            wt_req     <= act.wt;
            cb_req     <= act.cb;
            snoop_hitm <= act.hitm;
            wr_miss    <= act.miss;
            act_idx    <= ev_idx;
        end
    end

    assign qry_state  = st_q[qry_idx];
    assign flush_busy = sweep_busy;

    p_fill_exc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && !fill_pwt && fill_wbwt && flush_n && !flush_busy && !snoop_valid)
        |=> (st_q[$past(fill_idx)] == LN_EXC));

    p_fill_pwt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && fill_pwt && flush_n && !flush_busy && !snoop_valid)
        |=> (st_q[$past(fill_idx)] == LN_SHR));

    p_wt_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wt_req |-> (st_q[act_idx] == LN_SHR));

    p_hitm_cb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_hitm |-> cb_req);

    p_cb_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cb_req |-> (st_q[act_idx] == LN_INV || st_q[act_idx] == LN_SHR));

    p_sweep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (!wt_req && !wr_miss && !snoop_hitm));

    p_one_action_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wt_req, cb_req, wr_miss}) <= 1);

endmodule

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;

    localparam int N  = 8;
    localparam int IW = 3;

    typedef struct {
        logic          wt, cb, hitm, miss, busy;
        logic [IW-1:0] idx;
        logic [1:0]    qry;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_n = 1'b1;
    logic snoop_valid = 1'b0, snoop_hit = 1'b0, snoop_inv = 1'b0;
    logic [IW-1:0] snoop_idx = '0;
    logic fill_done = 1'b0, fill_pwt = 1'b0, fill_wbwt = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic wr_valid = 1'b0, wr_hit = 1'b0;
    logic [IW-1:0] wr_idx = '0, qry_idx = '0;
    logic [1:0] qry_state;
    logic flush_busy, wt_req, cb_req, snoop_hitm, wr_miss;
    logic [IW-1:0] act_idx;

    int checks = 0, errors = 0;
    bit done = 0;
    exp_t sb[$];

    logic [1:0] mdl [N];
    bit m_busy = 0;
    int m_ptr  = 0;

    always #2.5 clk = ~clk;

    mesi_line_ctrl #(.N_LINES(N)) u_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .flush_n(flush_n),
        .snoop_valid(snoop_valid), .snoop_hit(snoop_hit), .snoop_inv(snoop_inv), .snoop_idx(snoop_idx),
        .fill_done(fill_done), .fill_idx(fill_idx), .fill_pwt(fill_pwt), .fill_wbwt(fill_wbwt),
        .wr_valid(wr_valid), .wr_hit(wr_hit), .wr_idx(wr_idx), .qry_idx(qry_idx),
        .qry_state(qry_state), .flush_busy(flush_busy), .wt_req(wt_req), .cb_req(cb_req),
        .snoop_hitm(snoop_hitm), .wr_miss(wr_miss), .act_idx(act_idx)
    );

    // Driver: applies one clock of stimulus and pushes the model's expectation.
    task automatic step(input string tag, input logic fl, input logic sv, input logic sh,
                        input logic sinv, input int six, input logic fd, input int fix,
                        input logic fp, input logic fw, input logic wv, input logic wh,
                        input int wix, input int qix);
        exp_t e;
        @(negedge clk);
        flush_n = fl; snoop_valid = sv; snoop_hit = sh; snoop_inv = sinv; snoop_idx = IW'(six);
        fill_done = fd; fill_idx = IW'(fix); fill_pwt = fp; fill_wbwt = fw;
        wr_valid = wv; wr_hit = wh; wr_idx = IW'(wix); qry_idx = IW'(qix);
        e.wt = 0; e.cb = 0; e.hitm = 0; e.miss = 0; e.idx = '0; e.tag = tag;
        if (m_busy) begin
            e.idx = IW'(m_ptr);
            e.cb  = (mdl[m_ptr] == 2'b11);
            mdl[m_ptr] = 2'b00;
            if (m_ptr == N - 1) begin m_busy = 0; m_ptr = 0; end
            else m_ptr++;
        end else if (!fl) begin
            m_busy = 1; m_ptr = 0;
        end else if (sv) begin
            e.idx = IW'(six);
            if (sh) begin
                e.hitm = (mdl[six] == 2'b11);
                e.cb   = e.hitm;
                if (sinv) mdl[six] = 2'b00;
                else if (mdl[six] == 2'b11 || mdl[six] == 2'b10) mdl[six] = 2'b01;
            end
        end else if (fd) begin
            e.idx = IW'(fix);
            mdl[fix] = (fp || !fw) ? 2'b01 : 2'b10;
        end else if (wv) begin
            e.idx = IW'(wix);
            if (!wh || mdl[wix] == 2'b00) e.miss = 1;
            else if (mdl[wix] == 2'b01) e.wt = 1;
            else mdl[wix] = 2'b11;
        end
        e.busy = m_busy;
        e.qry  = mdl[qix];
        sb.push_back(e);
    endtask

    task automatic idle(input string tag, input int q);
        step(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, q);
    endtask
    task automatic fill(input string tag, input int i, input logic p, input logic w);
        step(tag, 1, 0, 0, 0, 0, 1, i, p, w, 0, 0, 0, i);
    endtask
    task automatic wr(input string tag, input int i, input logic h);
        step(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, h, i, i);
    endtask
    task automatic snp(input string tag, input int i, input logic h, input logic inv);
        step(tag, 1, 1, h, inv, i, 0, 0, 0, 0, 0, 0, 0, i);
    endtask

    // Monitor: pops one expectation per clock and compares after the edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            checks++;
            bad = (wt_req !== e.wt) || (cb_req !== e.cb) || (snoop_hitm !== e.hitm) ||
                  (wr_miss !== e.miss) || (flush_busy !== e.busy) || (qry_state !== e.qry) ||
                  ((e.wt || e.cb || e.hitm || e.miss) && act_idx !== e.idx);
            if (bad) begin
                errors++;
                $display("FAIL %s: actual wt=%b cb=%b hitm=%b miss=%b busy=%b idx=%0d qry=%b expected wt=%b cb=%b hitm=%b miss=%b busy=%b idx=%0d qry=%b",
                         e.tag, wt_req, cb_req, snoop_hitm, wr_miss, flush_busy, act_idx, qry_state,
                         e.wt, e.cb, e.hitm, e.miss, e.busy, e.idx, e.qry);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mdl[i] = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every line
        for (int i = 0; i < N; i++) idle("R1 reset invalid", i);
        // R2 / R3: fill policy
        fill("R2 fill wb -> exclusive", 0, 0, 1);
        fill("R2 fill wt -> shared", 1, 0, 0);
        fill("R3 pwt overrides wb", 2, 1, 1);
        fill("R3 pwt with wt", 3, 1, 0);
        // R4 / R5 / R6 / R7: writes
        wr("R4 write exclusive -> modified", 0, 1);
        wr("R6 write modified silent", 0, 1);
        wr("R5 write shared writes through", 1, 1);
        wr("R7 write to invalid line misses", 5, 1);
        wr("R7 write with hit low misses", 1, 0);
        // R9: snoop without invalidate
        snp("R9 snoop read on modified", 0, 1, 0);
        fill("R2 refill exclusive", 4, 0, 1);
        snp("R9 snoop read on exclusive", 4, 1, 0);
        snp("R9 snoop read on shared", 1, 1, 0);
        snp("R9 snoop miss no effect", 2, 0, 1);
        // R8: snoop with invalidate
        fill("R2 fill line 6", 6, 0, 1);
        wr("R4 dirty line 6", 6, 1);
        snp("R8 snoop kill modified", 6, 1, 1);
        snp("R8 snoop kill shared", 2, 1, 1);
        // R11: priority
        step("R11 snoop beats fill", 1, 1, 1, 1, 3, 1, 3, 0, 1, 0, 0, 0, 3);
        step("R11 fill beats write", 1, 0, 0, 0, 0, 1, 5, 0, 1, 1, 1, 1, 5);
        idle("R11 dropped write left line 1", 1);
        // dirty lines for the sweep
        wr("R4 dirty line 5", 5, 1);
        fill("R2 fill line 7", 7, 0, 1);
        wr("R4 dirty line 7", 7, 1);
        // R10 / R11: flush with a write in the same clock, events during sweep
        step("R11 flush beats write", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 4, 4);
        for (int i = 0; i < N; i++) begin
            if (i == 2) step("R11 fill dropped in sweep", 1, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, i);
            else if (i == 4) step("R11 snoop dropped in sweep", 1, 1, 1, 0, 5, 0, 0, 0, 0, 0, 0, 0, i);
            else idle("R10 sweep line", i);
        end
        for (int i = 0; i < N; i++) idle("R10 all invalid after sweep", i);
        // R12: post-sweep event timing
        fill("R12 fill after sweep", 3, 0, 0);
        wr("R12 write-through after sweep", 3, 1);
        idle("R12 quiet", 3);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule